// File: doc/BRIEF.md
# Framed Manchester Byte Transmitter

This block sends one byte at a time on a single-bit downlink line using Manchester coding. A send request taken while the block is idle captures the byte. The block then drives a two-bit preamble: a low start bit, then a sync bit that is high for its first half and low for its second half. Eight data bits follow, most significant bit first. Each data bit is the XOR of the bit with a square wave at the bit rate, so every data bit changes level exactly once, at its midpoint. Between frames the line rests high.

Bit timing comes from an internal divider. A parameter sets how many system clocks make up one half bit, so a system clock of 250 MHz with 5000 clocks per half bit gives a 25 kbps line. The block reports its current phase as a two-bit state code. A busy flag covers the whole frame, and a one-clock done pulse marks the end of the last data bit.

Top module: `mtx_frame_tx`

## Requirements
- R1: While reset is asserted and right after it is released, line_o is 1, busy_o is 0, done_o is 0 and state_o is 0.
- R2: In the idle state (state code 0) line_o stays 1 and busy_o is 0. The block leaves idle only when send_i is 1 at a rising clock edge.
- R3: In the clock after a send is accepted, the block enters the start state (code 1). It drives line_o to 0 for 2*HALF_CLKS clocks.
- R4: The sync state (code 2) follows start. line_o is 1 for HALF_CLKS clocks and then 0 for HALF_CLKS clocks.
- R5: The encode state (code 3) follows sync and lasts eight bit periods of 2*HALF_CLKS clocks each. Bits go out most significant first. A 1 is sent high then low, and a 0 is sent low then high (bit XOR half-phase, where the phase is 0 in the first half).
- R6: The byte on data_i is captured at the edge that accepts the send. Changes on data_i after that edge do not alter the frame.
- R7: done_o is 1 for exactly one clock: the first idle clock after the eighth data bit. busy_o is 1 in the start, sync and encode states.
- R8: send_i while busy has no effect. The frame is not restarted, and its state sequence and timing are unchanged.
- R9: A send presented in the clock where done_o is 1 is accepted. The next frame's start state begins on the following clock, with no idle gap.
- R10: Every half bit lasts exactly HALF_CLKS clocks, so a frame takes 20*HALF_CLKS clocks from the start state back to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| send_i | input | 1 | Request to send the byte on data_i |
| data_i | input | DATA_W | Byte to transmit |
| line_o | output | 1 | Manchester-coded downlink line |
| busy_o | output | 1 | High while a frame is in progress |
| done_o | output | 1 | One-clock pulse when a frame ends |
| state_o | output | 2 | Current state code: 0 idle, 1 start, 2 sync, 3 encode |

## Verification
Two functions can fall in the same clock: the end-of-frame done pulse and the acceptance of a new send request. The bench provokes this by raising send_i in the clock where done_o is high. It then checks that done_o is seen and that the next clock is already in the start state, with the new byte coded in full. A second overlap comes from random send_i and data_i toggling throughout every frame. Each such frame is judged clock by clock against a line and state model built from the captured byte, so any restart or data corruption shows up as a mismatch.

// File: rtl/mtx_pkg.sv
package mtx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_START  = 2'd1,
        ST_SYNC   = 2'd2,
        ST_ENCODE = 2'd3
    } tx_state_e;

endpackage

// File: rtl/mtx_half_timer.sv
module mtx_half_timer #(
    parameter int HALF_CLKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);
    localparam int CW = (HALF_CLKS > 1) ? $clog2(HALF_CLKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_CLKS - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (!run_i || r_q.cnt == LAST) begin
            r_d.cnt = '0;
        end else begin
            r_d.cnt = r_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign tick_o = run_i && (r_q.cnt == LAST);

endmodule

// File: rtl/mtx_shift_reg.sv
module mtx_shift_reg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              shift_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              msb_o
);
    typedef struct packed {
        logic [DATA_W-1:0] sr;
    } shr_t;

    shr_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (load_i) begin
            r_d.sr = data_i;
        end else if (shift_i) begin
            r_d.sr = {r_q.sr[DATA_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign msb_o = r_q.sr[DATA_W-1];

endmodule

// File: rtl/mtx_frame_fsm.sv
module mtx_frame_fsm
    import mtx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      send_i,
    input  logic      tick_i,
    output tx_state_e state_o,
    output logic      phase_o,
    output logic      load_o,
    output logic      shift_o,
    output logic      done_o
);
    localparam int BW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [BW-1:0] LAST_BIT = BW'(DATA_W - 1);

    typedef struct packed {
        tx_state_e     state;
        logic          phase;
        logic [BW-1:0] bitcnt;
        logic          done;
    } fsm_t;

    fsm_t r_d, r_q;
    logic load_d, shift_d;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        load_d   = 1'b0;
        shift_d  = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (send_i) begin
                    r_d.state  = ST_START;
                    r_d.phase  = 1'b0;
                    r_d.bitcnt = '0;
                    load_d     = 1'b1;
                end
            end
            default: begin
                if (tick_i) begin
                    if (!r_q.phase) begin
                        r_d.phase = 1'b1;
                    end else begin
                        r_d.phase = 1'b0;
                        unique case (r_q.state)
                            ST_START: r_d.state = ST_SYNC;
                            ST_SYNC: begin
                                r_d.state  = ST_ENCODE;
                                r_d.bitcnt = '0;
                            end
                            default: begin
                                shift_d = 1'b1;
                                if (r_q.bitcnt == LAST_BIT) begin
                                    r_d.state = ST_IDLE;
                                    r_d.done  = 1'b1;
                                end else begin
                                    r_d.bitcnt = r_q.bitcnt + 1'b1;
                                end
                            end
                        endcase
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, phase: 1'b0, bitcnt: '0, done: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign state_o = r_q.state;
    assign phase_o = r_q.phase;
    assign done_o  = r_q.done;
    assign load_o  = load_d;
    assign shift_o = shift_d;

endmodule

// File: rtl/mtx_frame_tx.sv
module mtx_frame_tx
    import mtx_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int HALF_CLKS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              send_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              line_o,
    output logic              busy_o,
    output logic              done_o,
    output logic [1:0]        state_o
);
    tx_state_e st;
    logic      phase, load, shift, tick, msb, running;

    assign running = (st != ST_IDLE);

    mtx_half_timer #(.HALF_CLKS(HALF_CLKS)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (running),
        .tick_o (tick)
    );

    mtx_frame_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .send_i  (send_i),
        .tick_i  (tick),
        .state_o (st),
        .phase_o (phase),
        .load_o  (load),
        .shift_o (shift),
        .done_o  (done_o)
    );

    mtx_shift_reg #(.DATA_W(DATA_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load),
        .shift_i (shift),
        .data_i  (data_i),
        .msb_o   (msb)
    );

    always_comb begin
        unique case (st)
            ST_IDLE:   line_o = 1'b1;
            ST_START:  line_o = 1'b0;
            ST_SYNC:   line_o = ~phase;
            default:   line_o = msb ^ phase;
        endcase
    end

    assign busy_o  = running;
    assign state_o = st;

endmodule

// File: rtl/mtx_frame_tx_chk.sv
module mtx_frame_tx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       line_o,
    input logic       busy_o,
    input logic       done_o,
    input logic [1:0] state_o
);
    AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'd0) |-> (line_o && !busy_o)); // R2

    AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'd1) |-> (!line_o && busy_o)); // R3

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R7

    AST_DONE_AFTER_ENC: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (state_o == 2'd0 && $past(state_o) == 2'd3)); // R7

    AST_START_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'd1 && $past(state_o) != 2'd1) |-> ($past(state_o) == 2'd0)); // R8

    AST_SYNC_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'd2 && $past(state_o) != 2'd2) |-> ($past(state_o) == 2'd1)); // R4

    AST_ENC_FROM_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'd3 && $past(state_o) != 2'd3) |-> ($past(state_o) == 2'd2)); // R5
endmodule

bind mtx_frame_tx mtx_frame_tx_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .line_o  (line_o),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .state_o (state_o)
);

// File: tb/mtx_frame_tx_bench.sv
module mtx_frame_tx_bench;
    localparam int DATA_W = 8;
    localparam int HALF   = 4;
    localparam int FRAME  = 20 * HALF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic send_i = 1'b0;
    logic [DATA_W-1:0] data_i = '0;
    logic line_o, busy_o, done_o;
    logic [1:0] state_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    mtx_frame_tx #(.DATA_W(DATA_W), .HALF_CLKS(HALF)) u_mtx_frame_tx (
        .clk(clk), .rst_n(rst_n), .send_i(send_i), .data_i(data_i),
        .line_o(line_o), .busy_o(busy_o), .done_o(done_o), .state_o(state_o)
    );

    function automatic logic exp_line(logic [7:0] b, int k);
        int half = k / HALF;
        int bi = half / 2;
        logic ph = logic'(half % 2);
        if (bi == 0) return 1'b0;
        if (bi == 1) return ~ph;
        return b[7 - (bi - 2)] ^ ph;
    endfunction

    function automatic logic [1:0] exp_state(int k);
        int bi = k / (2 * HALF);
        if (bi == 0) return 2'd1;
        if (bi == 1) return 2'd2;
        return 2'd3;
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_idle(string tag, logic exp_done);
        check(line_o == 1'b1, {tag, " line"}, line_o, 1);
        check(busy_o == 1'b0, {tag, " busy"}, busy_o, 0);
        check(state_o == 2'd0, {tag, " state"}, state_o, 0);
        check(done_o == exp_done, {tag, " done"}, done_o, exp_done);
    endtask

    // Called at a negedge with the block idle; returns at the negedge where done_o should be high.
    task automatic frame(logic [7:0] b, bit noise, string tag0);
        data_i = b;
        send_i = 1'b1;
        @(negedge clk);
        send_i = 1'b0;
        for (int k = 0; k < FRAME; k++) begin
            if (k == 0) check(state_o == 2'd1, tag0, state_o, 1);
            check(line_o == exp_line(b, k),
                  (k < 2*HALF) ? "R3 start line" : (k < 4*HALF) ? "R4 sync line" : "R5 R6 R8 data line",
                  line_o, exp_line(b, k));
            check(state_o == exp_state(k), "R8 R10 state sequence", state_o, exp_state(k));
            check(busy_o == 1'b1, "R7 busy in frame", busy_o, 1);
            if (noise) begin
                send_i = 1'($urandom);
                data_i = 8'($urandom);
            end
            @(negedge clk);
        end
        check(done_o == 1'b1, "R7 R10 done at frame end", done_o, 1);
        check(state_o == 2'd0, "R10 idle at frame end", state_o, 0);
        send_i = 1'b0;
    endtask

    task automatic gap(int n);
        @(negedge clk);
        check_idle("R7 done single pulse R2", 1'b0);
        for (int i = 1; i < n; i++) begin
            @(negedge clk);
            check_idle("R2 idle", 1'b0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        check_idle("R1 in reset", 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R1 after reset", 1'b0);
        gap(3);

        frame(8'h00, 1'b0, "R3 enter start");
        gap(2);
        frame(8'hFF, 1'b0, "R3 enter start");
        gap(2);
        frame(8'hA5, 1'b1, "R3 enter start");
        gap(4);
        frame(8'h3C, 1'b0, "R3 enter start");
        frame(8'hC3, 1'b1, "R9 back to back start");
        frame(8'h81, 1'b1, "R9 back to back start");
        gap(3);

        for (int n = 0; n < 20; n++) begin
            logic [7:0] b = 8'($urandom);
            frame(b, 1'b1, "R3 enter start");
            if ($urandom % 3 == 0) begin
                frame(~b, 1'b1, "R9 back to back start");
            end
            gap(1 + int'($urandom % 4));
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule